// File: doc/BRIEF.md
# Dual-Result 16-bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a small 16-bit processor datapath. It receives two operands and a three-bit operation code and answers, in the same cycle, with a primary result word. Multiply and divide also produce a secondary word. The surrounding datapath writes that secondary word into the register just above the destination.

Multiply and divide treat both operands as unsigned. A full 32-bit product is split into a low word and a high word. Division returns the quotient and the remainder together. Division by zero does not trap: it returns an all-ones quotient and hands back the dividend as the remainder.

Alongside every result, three status lines describe the first operand as a signed number: positive, negative or zero. These lines drive conditional branch decisions. They are valid whatever operation is selected.

Top module: `alu16_multi`

## Requirements
- R1: With op_sel 0 the primary result is opnd_a + opnd_b, and with op_sel 1 it is opnd_a - opnd_b, both wrapping modulo 2^16.
- R2: With op_sel 2 the primary result is the bitwise AND of the operands, and with op_sel 3 it is the inverse of their bitwise OR.
- R3: With op_sel 4 the operands are multiplied as unsigned numbers. The product's bits 15:0 appear on res_lo and its bits 31:16 appear on res_hi.
- R4: With op_sel 5 and a nonzero opnd_b, res_lo is the unsigned quotient opnd_a / opnd_b and res_hi is the unsigned remainder.
- R5: With op_sel 5 and opnd_b equal to zero, res_lo is 0xFFFF and res_hi equals opnd_a.
- R6: With op_sel 6 the primary result is opnd_a shifted right logically, and with op_sel 7 it is opnd_a shifted left logically. In both cases the shift count is opnd_b[3:0] and the upper bits of opnd_b have no effect.
- R7: hi_wr_en is 1 exactly when op_sel is 4 or 5. For every other operation res_hi is 0.
- R8: The status flags read opnd_a as a signed two's-complement number, for any op_sel. a_gt_zero is 1 when opnd_a is above zero, a_lt_zero is 1 when opnd_a[15] is set, and a_eq_zero is 1 when opnd_a is zero. Exactly one of the three is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code: 0 add, 1 sub, 2 and, 3 nor, 4 mul, 5 div, 6 srl, 7 sll |
| opnd_a | input | 16 | First operand; dividend, multiplicand, shifted value |
| opnd_b | input | 16 | Second operand; divisor, multiplier, shift count source |
| res_lo | output | 16 | Primary result |
| res_hi | output | 16 | Secondary result (product high word or remainder), else zero |
| hi_wr_en | output | 1 | Secondary result is meaningful and should be written |
| a_gt_zero | output | 1 | opnd_a is positive (signed) |
| a_lt_zero | output | 1 | opnd_a is negative (signed) |
| a_eq_zero | output | 1 | opnd_a is zero |

## Verification
The status flags and the arithmetic result are produced in the same cycle from the same first operand. A branch that follows a multiply or divide depends on both being correct together. Every vector in the sweep therefore judges all three flags alongside both result words and the write enable, including vectors where opnd_a is 0x8000, 0x0000 or 0xFFFF while a divide by zero forwards that same value to res_hi. The corner set crosses boundary words for each operation, and a pseudo-random stream follows it. Expected values come from integer arithmetic in the bench.

// File: rtl/alu16_pkg.sv
`timescale 1ns/1ps
package alu16_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_NOR = 3'd3,
    OP_MUL = 3'd4,
    OP_DIV = 3'd5,
    OP_SRL = 3'd6,
    OP_SLL = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu16_simple.sv
`timescale 1ns/1ps
// Single-result operations: add, sub, and, nor, logical shifts.
module alu16_simple
  import alu16_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  localparam int unsigned SHW = $clog2(WIDTH);

  logic [SHW-1:0]   shamt;
  logic [WIDTH-1:0] sum_w;
  logic [WIDTH-1:0] dif_w;

  assign shamt = b[SHW-1:0];
  assign sum_w = a + b;
  assign dif_w = a - b;

  always_comb begin
    unique case (op)
      OP_ADD:  y = sum_w;
      OP_SUB:  y = dif_w;
      OP_AND:  y = a & b;
      OP_NOR:  y = ~(a | b);
      OP_SRL:  y = a >> shamt;
      OP_SLL:  y = a << shamt;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu16_mul.sv
`timescale 1ns/1ps
// Unsigned array multiplier built from a chain of shifted partial products.
module alu16_mul #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] p
);
  localparam int unsigned PW = 2 * WIDTH;

  logic [PW-1:0] acc [0:WIDTH];

  assign acc[0] = '0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_row
    logic [PW-1:0] pp;
    assign pp         = b[i] ? ({{WIDTH{1'b0}}, a} << i) : '0;
    assign acc[i + 1] = acc[i] + pp;
  end

  assign p = acc[WIDTH];
endmodule

// File: rtl/alu16_div.sv
`timescale 1ns/1ps
// Unrolled restoring divider. A zero divisor falls out naturally as
// an all-ones quotient with the dividend left as remainder.
module alu16_div #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] r
);
  logic [WIDTH-1:0] part [0:WIDTH];

  assign part[0] = '0;

  for (genvar s = 0; s < WIDTH; s++) begin : g_stage
    localparam int unsigned BIT = WIDTH - 1 - s;
    logic [WIDTH:0] trial;
    logic [WIDTH:0] diff;
    logic           fits;
    assign trial       = {part[s], n[BIT]};
    assign diff        = trial - {1'b0, d};
    assign fits        = (trial >= {1'b0, d});
    assign q[BIT]      = fits;
    assign part[s + 1] = fits ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
  end

  assign r = part[WIDTH];
endmodule

// File: rtl/alu16_flags.sv
`timescale 1ns/1ps
// Signed sign/zero classification of the first operand.
module alu16_flags #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  output logic             gtz,
  output logic             ltz,
  output logic             eqz
);
  assign eqz = (a == '0);
  assign ltz = a[WIDTH-1];
  assign gtz = ~eqz & ~ltz;
endmodule

// File: rtl/alu16_multi.sv
`timescale 1ns/1ps
module alu16_multi
  import alu16_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] res_lo,
  output logic [WIDTH-1:0] res_hi,
  output logic             hi_wr_en,
  output logic             a_gt_zero,
  output logic             a_lt_zero,
  output logic             a_eq_zero
);
  alu_op_e            op;
  logic [WIDTH-1:0]   simple_y;
  logic [2*WIDTH-1:0] prod;
  logic [WIDTH-1:0]   quo;
  logic [WIDTH-1:0]   rem;

  assign op = alu_op_e'(op_sel);

  alu16_simple #(.WIDTH(WIDTH)) u_simple (
    .op(op), .a(opnd_a), .b(opnd_b), .y(simple_y)
  );

  alu16_mul #(.WIDTH(WIDTH)) u_mul (
    .a(opnd_a), .b(opnd_b), .p(prod)
  );

  alu16_div #(.WIDTH(WIDTH)) u_div (
    .n(opnd_a), .d(opnd_b), .q(quo), .r(rem)
  );

  alu16_flags #(.WIDTH(WIDTH)) u_flags (
    .a(opnd_a), .gtz(a_gt_zero), .ltz(a_lt_zero), .eqz(a_eq_zero)
  );

  always_comb begin
    res_lo   = simple_y;
    res_hi   = '0;
    hi_wr_en = 1'b0;
    unique case (op)
      OP_MUL: begin
        res_lo   = prod[WIDTH-1:0];
        res_hi   = prod[2*WIDTH-1:WIDTH];
        hi_wr_en = 1'b1;
      end
      OP_DIV: begin
        res_lo   = quo;
        res_hi   = rem;
        hi_wr_en = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu16_multi_chk.sv
`timescale 1ns/1ps
module alu16_multi_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [WIDTH-1:0] res_lo,
  input logic [WIDTH-1:0] res_hi,
  input logic             hi_wr_en,
  input logic             a_gt_zero,
  input logic             a_lt_zero,
  input logic             a_eq_zero
);
  logic [2*WIDTH-1:0] wide_a, wide_b, wide_q, wide_r, wide_p;

  assign wide_a = {{WIDTH{1'b0}}, opnd_a};
  assign wide_b = {{WIDTH{1'b0}}, opnd_b};
  assign wide_q = {{WIDTH{1'b0}}, res_lo};
  assign wide_r = {{WIDTH{1'b0}}, res_hi};
  assign wide_p = wide_a * wide_b;

  always_comb begin
    if (op_sel == 3'd4) begin
      a_r3_product: assert ({res_hi, res_lo} == wide_p);
    end
    if (op_sel == 3'd5 && opnd_b != '0) begin
      a_r4_div_identity: assert ((res_hi < opnd_b) && (wide_q * wide_b + wide_r == wide_a));
    end
    if (op_sel == 3'd5 && opnd_b == '0) begin
      a_r5_div_by_zero: assert ((res_lo == '1) && (res_hi == opnd_a));
    end
    if (!hi_wr_en) begin
      a_r7_hi_quiet: assert (res_hi == '0);
    end
    a_r8_one_flag: assert ($countones({a_gt_zero, a_lt_zero, a_eq_zero}) == 1);
  end
endmodule

bind alu16_multi alu16_multi_chk #(.WIDTH(WIDTH)) u_chk (
  .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .res_lo(res_lo), .res_hi(res_hi), .hi_wr_en(hi_wr_en),
  .a_gt_zero(a_gt_zero), .a_lt_zero(a_lt_zero), .a_eq_zero(a_eq_zero)
);

// File: tb/alu16_multi_test.sv
`timescale 1ns/1ps
module alu16_multi_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [15:0] opnd_a = 16'h0;
  logic [15:0] opnd_b = 16'h0;
  logic [15:0] res_lo, res_hi;
  logic        hi_wr_en, a_gt_zero, a_lt_zero, a_eq_zero;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  alu16_multi uut (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_lo(res_lo), .res_hi(res_hi), .hi_wr_en(hi_wr_en),
    .a_gt_zero(a_gt_zero), .a_lt_zero(a_lt_zero), .a_eq_zero(a_eq_zero)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp,
                     input logic [2:0] op, input logic [15:0] a,
                     input logic [15:0] b);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h",
               tag, what, op, a, b, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [15:0] a,
                     input logic [15:0] b);
    longint unsigned ua, ub, pr;
    logic [15:0] e_lo, e_hi;
    logic        e_we;
    string       tag;
    ua = longint'(a);
    ub = longint'(b);
    e_hi = 16'h0;
    e_we = 1'b0;
    case (op)
      3'd0: begin tag = "R1"; e_lo = 16'((ua + ub) % 65536); end
      3'd1: begin tag = "R1"; e_lo = 16'((ua + 65536 - ub) % 65536); end
      3'd2: begin tag = "R2"; e_lo = a & b; end
      3'd3: begin tag = "R2"; e_lo = 16'(65535 - (ua | ub)); end
      3'd4: begin
        tag = "R3"; pr = ua * ub;
        e_lo = 16'(pr % 65536); e_hi = 16'(pr / 65536); e_we = 1'b1;
      end
      3'd5: begin
        e_we = 1'b1;
        if (ub == 0) begin tag = "R5"; e_lo = 16'hFFFF; e_hi = a; end
        else begin tag = "R4"; e_lo = 16'(ua / ub); e_hi = 16'(ua % ub); end
      end
      3'd6: begin tag = "R6"; e_lo = 16'(ua / (longint'(1) << (ub % 16))); end
      default: begin tag = "R6"; e_lo = 16'((ua * (longint'(1) << (ub % 16))) % 65536); end
    endcase
    @(posedge clk);
    op_sel <= op; opnd_a <= a; opnd_b <= b;
    @(negedge clk);
    cmp(tag, "res_lo", res_lo, e_lo, op, a, b);
    cmp((op == 3'd4 || op == 3'd5) ? tag : "R7", "res_hi", res_hi, e_hi, op, a, b);
    cmp("R7", "hi_wr_en", {15'h0, hi_wr_en}, {15'h0, e_we}, op, a, b);
    // R8: signed view of opnd_a
    cmp("R8", "flags", {13'h0, a_gt_zero, a_lt_zero, a_eq_zero},
        {13'h0, (a != 0 && !a[15]), a[15], (a == 0)}, op, a, b);
  endtask

  logic [15:0] corner [0:11];
  initial begin
    corner[0]  = 16'h0000; corner[1]  = 16'h0001; corner[2]  = 16'h0002;
    corner[3]  = 16'h000F; corner[4]  = 16'h0010; corner[5]  = 16'h0011;
    corner[6]  = 16'h7FFF; corner[7]  = 16'h8000; corner[8]  = 16'h8001;
    corner[9]  = 16'hFFFF; corner[10] = 16'hA5C3; corner[11] = 16'h00FF;
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    // Idle inputs (add of zeros): all results zero, eq flag set (R1, R7, R8)
    cmp("R1", "idle res_lo", res_lo, 16'h0, 3'd0, 16'h0, 16'h0);
    cmp("R7", "idle res_hi", res_hi, 16'h0, 3'd0, 16'h0, 16'h0);
    cmp("R8", "idle eq", {15'h0, a_eq_zero}, 16'h1, 3'd0, 16'h0, 16'h0);
    // Corner cross product over all operations
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          run(3'(op), corner[i], corner[j]);
    // R6: upper bits of the count ignored
    run(3'd6, 16'hF0F0, 16'hFFF4);
    run(3'd7, 16'h0F0F, 16'h1230);
    // R5: divide by zero on signed-boundary dividends
    run(3'd5, 16'h8000, 16'h0000);
    run(3'd5, 16'h1234, 16'h0000);
    // Pseudo-random stream
    for (int k = 0; k < 4000; k++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      run(3'(k % 8), lfsr[31:16], (k % 16 == 5) ? 16'h0 : lfsr[15:0]);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule